// File: doc/BRIEF.md
# Serial Channel Status and Interrupt Unit

This block holds the status flags and produces the interrupt request for one channel of an asynchronous serial port. The receiver reports each completed byte, each overrun, each parity failure and each bad stop bit as a single-cycle strobe. The transmitter reports a software write into its holding buffer and the later move of that byte into the shift register. The block turns these strobes into sticky flags. It presents them as one 8-bit status value. The only writable field in that value is a receive-interrupt enable. From the flags and the enable it drives a level interrupt request.

Two pins arrive from outside the chip without any timing relation to the clock. Each passes through its own synchronizer before it is used. A high carrier-detect pin holds the receive side in reset and wipes the receive flags. Its rising edge is latched as an interrupt cause. A high clear-to-send pin hides the transmit-empty indication. An I/O stop mode input puts both directions back into their idle state.

Top module: `ser_stat_irq`

## Requirements
- R1: After reset the status value reads 0x01, so only the transmit-empty bit (bit 0) is set. The interrupt request is 0 and the receive-hold output is 0.
- R2: The data-full flag (bit 6) sets on a byte-received strobe and clears on a receive-buffer take strobe. If both strobes arrive in the same cycle, the set wins.
- R3: The overrun flag (bit 5) and the framing flag (bit 3) set on their strobes. The parity flag (bit 4) sets on a parity-failure strobe only while the parity-enable input is 1.
- R4: A control write with the clear bit at 0 clears overrun, parity and framing. A control write with the clear bit at 1 leaves all three flags unchanged. If a new error strobe arrives in the same cycle as the clearing write, that flag is set.
- R5: While the carrier status bit is 1, the receive-hold output is 1. In that state the data-full, overrun, parity and framing flags are cleared and receive strobes are ignored. I/O stop mode clears the same four flags.
- R6: The carrier status bit (bit 1) follows the pin with a two-flop synchronizer delay while the pin is high. After the pin falls, the bit stays 1 until the first status read.
- R7: A synchronized low-to-high carrier transition latches a carrier event. The event is held until a status read. If a new edge arrives in the same cycle as the read, the event stays set.
- R8: The interrupt request is 1 exactly when the enable (bit 2) is 1 and at least one of these is set: data-full, overrun, parity, framing, or the carrier event.
- R9: The transmit-empty state clears on a buffer write and sets on a buffer-to-shift transfer. If both arrive in the same cycle, the write wins. I/O stop mode forces the state to 1.
- R10: While the synchronized clear-to-send pin is high, bit 0 reads 0. The underlying transmit-empty state is kept and shows again when the pin falls.
- R11: A status write loads only the enable from write-data bit 2. All other written bits are ignored. Bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_done_i | input | 1 | Byte-received strobe |
| rx_ovr_i | input | 1 | Overrun strobe |
| rx_par_i | input | 1 | Parity-failure strobe |
| rx_frm_i | input | 1 | Bad-stop-bit strobe |
| rx_take_i | input | 1 | Receive buffer taken by software |
| par_en_i | input | 1 | Parity checking enabled |
| iostop_i | input | 1 | I/O stop mode |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_clr_i | input | 1 | Error-clear bit value of that write (0 clears) |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| tx_load_i | input | 1 | Buffer-to-shift-register transfer strobe |
| dcd_pin_i | input | 1 | Asynchronous carrier-detect pin |
| cts_pin_i | input | 1 | Asynchronous clear-to-send pin |
| st_rd_i | input | 1 | Status read strobe |
| st_wr_i | input | 1 | Status write strobe |
| st_wdata_i | input | 8 | Status write data |
| st_rdata_o | output | 8 | Status read value |
| irq_o | output | 1 | Interrupt request level |
| rx_hold_o | output | 1 | Receive section held in reset |

## Verification
Two pairs of events can land in the same cycle, and each pair has a defined winner. A transmit-buffer write can coincide with a buffer-to-shift transfer, and a clearing control write can coincide with a fresh error strobe. The random stimulus raises each strobe independently, so both pairs occur often. Directed sequences also force each pair once and check the literal status value afterwards. A cycle-level bench model derived from the requirements judges every cycle. It applies the stated winners: the write wins for transmit-empty, and the set wins for the error flags.

// File: rtl/ser_stat_pkg.sv
// Package: bit positions of the status value shared by the unit and its checker.
// Assumes an 8-bit status value; bit 7 is reserved and reads 0.
package ser_stat_pkg;
    localparam int STAT_W = 8;
    localparam int B_TXE  = 0;
    localparam int B_DCD  = 1;
    localparam int B_RIE  = 2;
    localparam int B_FE   = 3;
    localparam int B_PE   = 4;
    localparam int B_OVR  = 5;
    localparam int B_RDF  = 6;
endpackage

// File: rtl/ssi_sync.sv
// Multi-flop synchronizer for one asynchronous pin.
// Assumes STAGES >= 2; output is cleared by the synchronous reset.
module ssi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh;

    // Shift the pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d_i};
    end

    assign q_o = sh[STAGES-1];
endmodule

// File: rtl/ssi_rx_flags.sv
// Receive-side sticky flags: data-full, overrun, parity, framing.
// Assumes strobes are single-cycle. Hold and stop mode clear all flags.
// Within the error flags a new event wins over a clearing control write.
module ssi_rx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic iostop_i,
    input  logic rx_done_i,
    input  logic rx_ovr_i,
    input  logic rx_par_i,
    input  logic rx_frm_i,
    input  logic rx_take_i,
    input  logic par_en_i,
    input  logic err_clr_i,
    output logic rdf_o,
    output logic ovr_o,
    output logic pe_o,
    output logic fe_o
);
    logic wipe;
    assign wipe = hold_i | iostop_i;   // R5: receive side in reset

    // Data-full flag: set on byte received, cleared on take (R2).
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)  rdf_o <= 1'b0;
        else if (rx_done_i)  rdf_o <= 1'b1;
        else if (rx_take_i)  rdf_o <= 1'b0;
    end

    // Error flags: set on strobe, cleared by control write of 0 (R3, R4).
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            ovr_o <= 1'b0;
            pe_o  <= 1'b0;
            fe_o  <= 1'b0;
        end else begin
            if (rx_ovr_i)              ovr_o <= 1'b1;
            else if (err_clr_i)        ovr_o <= 1'b0;
            if (rx_par_i && par_en_i)  pe_o  <= 1'b1;
            else if (err_clr_i)        pe_o  <= 1'b0;
            if (rx_frm_i)              fe_o  <= 1'b1;
            else if (err_clr_i)        fe_o  <= 1'b0;
        end
    end
endmodule

// File: rtl/ssi_dcd_track.sv
// Carrier status bit and carrier rising-edge event latch.
// Assumes dcd_i is already synchronized to clk.
module ssi_dcd_track (
    input  logic clk,
    input  logic rst_n,
    input  logic dcd_i,
    input  logic st_rd_i,
    output logic dcd_st_o,
    output logic evt_o
);
    logic dcd_q;

    // Delay copy of the synchronized pin for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dcd_q <= 1'b0;
        else        dcd_q <= dcd_i;
    end

    // Status bit: high with the pin, cleared by the first read after it falls (R6).
    always_ff @(posedge clk) begin
        if (!rst_n)       dcd_st_o <= 1'b0;
        else if (dcd_i)   dcd_st_o <= 1'b1;
        else if (st_rd_i) dcd_st_o <= 1'b0;
    end

    // Edge event latch: set on rising edge, cleared by a read; set wins (R7).
    always_ff @(posedge clk) begin
        if (!rst_n)               evt_o <= 1'b0;
        else if (dcd_i && !dcd_q) evt_o <= 1'b1;
        else if (st_rd_i)         evt_o <= 1'b0;
    end
endmodule

// File: rtl/ssi_tx_flag.sv
// Transmit-empty state with clear-to-send masking of the reported bit.
// Assumes cts_i is synchronized. Stop mode forces the state to empty.
module ssi_tx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic iostop_i,
    input  logic tx_wr_i,
    input  logic tx_load_i,
    input  logic cts_i,
    output logic txe_o
);
    logic empty;

    // Buffer state: write empties nothing, load frees the buffer; write wins (R9).
    always_ff @(posedge clk) begin
        if (!rst_n || iostop_i) empty <= 1'b1;
        else if (tx_wr_i)       empty <= 1'b0;
        else if (tx_load_i)     empty <= 1'b1;
    end

    assign txe_o = empty & ~cts_i;   // R10: masked, state kept
endmodule

// File: rtl/ser_stat_irq.sv
// Status and interrupt unit for one serial channel.
// Synchronizes the carrier and clear-to-send pins and keeps the receive and transmit flags.
// Packs the flags into the status value and drives a level interrupt.
// Assumes all strobes are single-cycle and synchronous to clk.
module ser_stat_irq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_done_i,
    input  logic       rx_ovr_i,
    input  logic       rx_par_i,
    input  logic       rx_frm_i,
    input  logic       rx_take_i,
    input  logic       par_en_i,
    input  logic       iostop_i,
    input  logic       ctl_wr_i,
    input  logic       ctl_clr_i,
    input  logic       tx_wr_i,
    input  logic       tx_load_i,
    input  logic       dcd_pin_i,
    input  logic       cts_pin_i,
    input  logic       st_rd_i,
    input  logic       st_wr_i,
    input  logic [7:0] st_wdata_i,
    output logic [7:0] st_rdata_o,
    output logic       irq_o,
    output logic       rx_hold_o
);
    import ser_stat_pkg::*;

    localparam int NPIN = 2;

    logic [NPIN-1:0] pin_raw, pin_s;
    logic dcd_s, cts_s;
    logic dcd_st, dcd_evt, rie;
    logic rdf, ovr, pe, fe, txe;
    logic unused_wbits;

    assign pin_raw = {cts_pin_i, dcd_pin_i};

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_sync
            ssi_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk(clk), .rst_n(rst_n), .d_i(pin_raw[g]), .q_o(pin_s[g])
            );
        end
    endgenerate

    assign dcd_s = pin_s[0];
    assign cts_s = pin_s[1];

    ssi_dcd_track u_dcd (
        .clk(clk), .rst_n(rst_n), .dcd_i(dcd_s), .st_rd_i(st_rd_i),
        .dcd_st_o(dcd_st), .evt_o(dcd_evt)
    );

    ssi_rx_flags u_rx (
        .clk(clk), .rst_n(rst_n), .hold_i(dcd_st), .iostop_i(iostop_i),
        .rx_done_i(rx_done_i), .rx_ovr_i(rx_ovr_i), .rx_par_i(rx_par_i),
        .rx_frm_i(rx_frm_i), .rx_take_i(rx_take_i), .par_en_i(par_en_i),
        .err_clr_i(ctl_wr_i & ~ctl_clr_i),
        .rdf_o(rdf), .ovr_o(ovr), .pe_o(pe), .fe_o(fe)
    );

    ssi_tx_flag u_tx (
        .clk(clk), .rst_n(rst_n), .iostop_i(iostop_i), .tx_wr_i(tx_wr_i),
        .tx_load_i(tx_load_i), .cts_i(cts_s), .txe_o(txe)
    );

    // Interrupt enable: the only writable status field (R11).
    always_ff @(posedge clk) begin
        if (!rst_n)       rie <= 1'b0;
        else if (st_wr_i) rie <= st_wdata_i[B_RIE];
    end

    assign unused_wbits = ^{st_wdata_i[7:B_RIE+1], st_wdata_i[B_RIE-1:0]};

    // Pack the status value.
    always_comb begin
        st_rdata_o        = '0;
        st_rdata_o[B_TXE] = txe;
        st_rdata_o[B_DCD] = dcd_st;
        st_rdata_o[B_RIE] = rie;
        st_rdata_o[B_FE]  = fe;
        st_rdata_o[B_PE]  = pe;
        st_rdata_o[B_OVR] = ovr;
        st_rdata_o[B_RDF] = rdf;
    end

    assign irq_o     = rie & (rdf | ovr | pe | fe | dcd_evt);   // R8
    assign rx_hold_o = dcd_st;                                   // R5
endmodule

// File: rtl/ser_stat_irq_chk.sv
// Checker for ser_stat_irq: temporal properties over ports and the synchronized pins.
// Assumes it is attached by the bind at the end of this file.
module ser_stat_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_done_i,
    input logic       rx_ovr_i,
    input logic       rx_par_i,
    input logic       rx_frm_i,
    input logic       par_en_i,
    input logic       iostop_i,
    input logic       ctl_wr_i,
    input logic       ctl_clr_i,
    input logic       tx_wr_i,
    input logic       dcd_s,
    input logic       cts_s,
    input logic [7:0] st_rdata_o,
    input logic       irq_o,
    input logic       rx_hold_o
);
    p_dfull_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i && !rx_hold_o && !iostop_i) |=> st_rdata_o[6]);

    p_par_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_rdata_o[4] && !par_en_i) |=> !st_rdata_o[4]);

    p_err_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && !ctl_clr_i && !rx_ovr_i && !rx_par_i && !rx_frm_i)
        |=> (st_rdata_o[5:3] == 3'b000));

    p_hold_wipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_hold_o |=> (st_rdata_o[6:3] == 4'b0000));

    p_dcd_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dcd_s |=> st_rdata_o[1]);

    p_irq_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_rdata_o[2] |-> !irq_o);

    p_tx_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_i && !iostop_i) |=> !st_rdata_o[0]);

    p_cts_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cts_s |-> !st_rdata_o[0]);

    p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !st_rdata_o[7]);
endmodule

bind ser_stat_irq ser_stat_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_done_i(rx_done_i), .rx_ovr_i(rx_ovr_i),
    .rx_par_i(rx_par_i), .rx_frm_i(rx_frm_i), .par_en_i(par_en_i),
    .iostop_i(iostop_i), .ctl_wr_i(ctl_wr_i), .ctl_clr_i(ctl_clr_i),
    .tx_wr_i(tx_wr_i), .dcd_s(dcd_s), .cts_s(cts_s),
    .st_rdata_o(st_rdata_o), .irq_o(irq_o), .rx_hold_o(rx_hold_o)
);

// File: tb/ser_stat_irq_test.sv
// Bench: seeded random strobes plus directed corner cases, checked every cycle against a requirement model.
module ser_stat_irq_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 4000;

    logic clk = 1'b0;
    logic rst_n;
    logic rx_done_i, rx_ovr_i, rx_par_i, rx_frm_i, rx_take_i, par_en_i, iostop_i;
    logic ctl_wr_i, ctl_clr_i, tx_wr_i, tx_load_i, dcd_pin_i, cts_pin_i;
    logic st_rd_i, st_wr_i;
    logic [7:0] st_wdata_i, st_rdata_o;
    logic irq_o, rx_hold_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_stat_irq uut (.*);

    // Requirement model state.
    logic m_d1, m_d2, m_dq, m_c1, m_c2;
    logic m_rdf, m_ovr, m_pe, m_fe, m_dcd, m_evt, m_rie, m_txe;

    always @(posedge clk) begin
        logic wipe, clr, rise;
        if (!rst_n) begin
            {m_d1, m_d2, m_dq, m_c1, m_c2} = '0;
            {m_rdf, m_ovr, m_pe, m_fe, m_dcd, m_evt, m_rie} = '0;
            m_txe = 1'b1;
        end else begin
            wipe = m_dcd | iostop_i;
            clr  = ctl_wr_i & ~ctl_clr_i;
            rise = m_d2 & ~m_dq;
            m_rdf = wipe ? 1'b0 : rx_done_i ? 1'b1 : rx_take_i ? 1'b0 : m_rdf;
            m_ovr = wipe ? 1'b0 : rx_ovr_i ? 1'b1 : clr ? 1'b0 : m_ovr;
            m_pe  = wipe ? 1'b0 : (rx_par_i & par_en_i) ? 1'b1 : clr ? 1'b0 : m_pe;
            m_fe  = wipe ? 1'b0 : rx_frm_i ? 1'b1 : clr ? 1'b0 : m_fe;
            m_evt = rise ? 1'b1 : st_rd_i ? 1'b0 : m_evt;
            m_dcd = m_d2 ? 1'b1 : st_rd_i ? 1'b0 : m_dcd;
            m_rie = st_wr_i ? st_wdata_i[2] : m_rie;
            m_txe = iostop_i ? 1'b1 : tx_wr_i ? 1'b0 : tx_load_i ? 1'b1 : m_txe;
            m_dq = m_d2; m_d2 = m_d1; m_d1 = dcd_pin_i;
            m_c2 = m_c1; m_c1 = cts_pin_i;
        end
    end

    function automatic logic [7:0] exp_stat();
        return {1'b0, m_rdf, m_ovr, m_pe, m_fe, m_rie, m_dcd, m_txe & ~m_c2};
    endfunction

    function automatic logic exp_irq();
        return m_rie & (m_rdf | m_ovr | m_pe | m_fe | m_evt);
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare every field against the model, each under its requirement.
    task automatic cmp_all();
        logic [7:0] e;
        e = exp_stat();
        chk("R2 data-full",    {7'd0, st_rdata_o[6]}, {7'd0, e[6]});
        chk("R3/R4 errors",    {5'd0, st_rdata_o[5:3]}, {5'd0, e[5:3]});
        chk("R11 enable/rsvd", {st_rdata_o[7], 6'd0, st_rdata_o[2]}, {e[7], 6'd0, e[2]});
        chk("R6 carrier",      {7'd0, st_rdata_o[1]}, {7'd0, e[1]});
        chk("R9/R10 tx-empty", {7'd0, st_rdata_o[0]}, {7'd0, e[0]});
        chk("R7/R8 irq",       {7'd0, irq_o}, {7'd0, exp_irq()});
        chk("R5 hold",         {7'd0, rx_hold_o}, {7'd0, m_dcd});
    endtask

    task automatic idle();
        {rx_done_i, rx_ovr_i, rx_par_i, rx_frm_i, rx_take_i, iostop_i} = '0;
        {ctl_wr_i, ctl_clr_i, tx_wr_i, tx_load_i, st_rd_i, st_wr_i} = '0;
        st_wdata_i = '0;
    endtask

    // One cycle: inputs already driven; wait to the falling edge and compare.
    task automatic step();
        @(negedge clk);
        cmp_all();
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4711);
        idle();
        par_en_i = 1'b1; dcd_pin_i = 1'b0; cts_pin_i = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 status", st_rdata_o, 8'h01);
        chk("R1 irq/hold", {6'd0, irq_o, rx_hold_o}, 8'h00);

        // R11: write all ones, only the enable bit lands
        st_wr_i = 1'b1; st_wdata_i = 8'hFF; step();
        chk("R11 write mask", st_rdata_o, 8'h05);

        // R9: write and load in the same cycle, write wins
        tx_wr_i = 1'b1; tx_load_i = 1'b1; step();
        chk("R9 write wins", {7'd0, st_rdata_o[0]}, 8'h00);
        tx_load_i = 1'b1; step();
        chk("R9 load sets", {7'd0, st_rdata_o[0]}, 8'h01);

        // R3: parity strobe ignored while parity disabled
        par_en_i = 1'b0; rx_par_i = 1'b1; step();
        chk("R3 parity gated", {7'd0, st_rdata_o[4]}, 8'h00);
        par_en_i = 1'b1; rx_par_i = 1'b1; step();
        chk("R3 parity set", {7'd0, st_rdata_o[4]}, 8'h01);

        // R4: clearing write colliding with a framing strobe; write of 1 keeps flags
        ctl_wr_i = 1'b1; ctl_clr_i = 1'b1; step();
        chk("R4 write one keeps", {5'd0, st_rdata_o[5:3]}, 8'h02);
        ctl_wr_i = 1'b1; ctl_clr_i = 1'b0; rx_frm_i = 1'b1; step();
        chk("R4 set wins", {5'd0, st_rdata_o[5:3]}, 8'h01);
        chk("R8 irq on flag", {7'd0, irq_o}, 8'h01);

        // R10: clear-to-send masks tx-empty, then restores it
        cts_pin_i = 1'b1; repeat (3) step();
        chk("R10 masked", {7'd0, st_rdata_o[0]}, 8'h00);
        cts_pin_i = 1'b0; repeat (3) step();
        chk("R10 restored", {7'd0, st_rdata_o[0]}, 8'h01);

        // R5/R6/R7: carrier rises, holds receiver, falls, cleared by read
        dcd_pin_i = 1'b1; repeat (4) step();
        rx_done_i = 1'b1; step();
        chk("R5 ignored while held", {7'd0, st_rdata_o[6]}, 8'h00);
        dcd_pin_i = 1'b0; repeat (4) step();
        chk("R6 sticky after fall", {7'd0, st_rdata_o[1]}, 8'h01);
        st_rd_i = 1'b1; step();
        chk("R6/R7 read clears", {6'd0, st_rdata_o[1], irq_o}, 8'h00);

        // Random phase, compared every cycle.
        for (int i = 0; i < N_RAND; i++) begin
            rx_done_i  = ($urandom % 8) == 0;
            rx_ovr_i   = ($urandom % 16) == 0;
            rx_par_i   = ($urandom % 12) == 0;
            rx_frm_i   = ($urandom % 12) == 0;
            rx_take_i  = ($urandom % 8) == 0;
            ctl_wr_i   = ($urandom % 10) == 0;
            ctl_clr_i  = $urandom % 2;
            tx_wr_i    = ($urandom % 5) == 0;
            tx_load_i  = ($urandom % 5) == 0;
            st_rd_i    = ($urandom % 14) == 0;
            st_wr_i    = ($urandom % 30) == 0;
            st_wdata_i = 8'($urandom);
            iostop_i   = ($urandom % 90) == 0;
            if (($urandom % 120) == 0) par_en_i = ~par_en_i;
            if (($urandom % 60) == 0)  dcd_pin_i = ~dcd_pin_i;
            if (($urandom % 50) == 0)  cts_pin_i = ~cts_pin_i;
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule